// File: doc/BRIEF.md
# Serial ADC Frame Read Controller

This block is the host-side master for a small successive-approximation converter with a three-wire serial port: an active-low chip select, a serial clock and a serial data return line. From the system clock it builds the chip select and a serial clock at a run-time divided rate. It captures the returned bits, checks the two zero bits that lead every frame, and hands the sample out as a parallel word with a one-cycle valid strobe.

A host issues one of three commands through a start/ready handshake. A read runs a full 16-clock frame and returns a sample. A sleep command drops chip select for a 3-clock stub, which puts the converter into its low-power state. A wake command runs three full dummy frames so the converter has time to power up. After each frame the block holds chip select high for a programmable quiet time before it accepts the next command. Results of frames run while the converter sleeps are discarded.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset and between frames `cs_n_o` and `sclk_o` are both 1. A read (`cmd_i` = 2'b00) drives `cs_n_o` low in the cycle after `start_i` is taken. The first `sclk_o` fall follows H cycles later. The frame has exactly 16 `sclk_o` falls, and `sclk_o` is low only while `cs_n_o` is low.
- R2: Every low phase and every high phase of `sclk_o` lasts exactly H system cycles. H is `half_div_i`, and a value of 0 counts as 1. The chip select releases after the high phase of the last clock.
- R3: `sdo_i` is sampled `cap_dly_i`+1 cycles after each launch event. The first launch event is the chip-select fall, and each `sclk_o` fall is another. Values of `cap_dly_i` at or above H count as H-1. The first 2+DATA_W samples form the frame. The bits after the two leading ones form `result_o`, MSB first. `valid_o` is a one-cycle pulse in the first cycle with `cs_n_o` high again.
- R4: `frame_err_o` pulses together with `valid_o` when either of the two leading samples was 1. The data bits are still delivered.
- R5: A sleep command (`cmd_i` = 2'b01) releases `cs_n_o` after exactly 3 `sclk_o` clocks, produces no `valid_o`, and marks the converter as asleep.
- R6: A wake command (`cmd_i` = 2'b10) runs exactly 3 frames of 16 clocks each, with the quiet time between them, produces no `valid_o`, and marks the converter as awake.
- R7: A read issued while the converter is asleep runs a full 16-clock frame but produces no `valid_o`.
- R8: After every chip-select rise, `cs_n_o` stays high for Q cycles before a following frame begins or `ready_o` returns to 1. Q is `quiet_i`, and a value of 0 counts as 1. `ready_o` is 1 only while idle.
- R9: `half_div_i`, `quiet_i` and `cap_dly_i` are sampled at each frame start. Changing them during a frame does not alter that frame's clock phases or its quiet time.
- R10: The reserved command 2'b11 is ignored. `cs_n_o` stays high and `ready_o` stays 1.
- R11: The converter is taken as awake after reset, so the first read returns a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command request, taken while `ready_o` is 1 |
| cmd_i | input | 2 | 00 read, 01 sleep, 10 wake, 11 reserved |
| half_div_i | input | DIV_W | Serial clock half period in system cycles |
| quiet_i | input | QUIET_W | Chip-select high time after a frame, in system cycles |
| cap_dly_i | input | DIV_W | Extra cycles from a launch edge to the data sample |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| ready_o | output | 1 | Controller idle and able to take a command |
| result_o | output | DATA_W | Last returned sample |
| valid_o | output | 1 | One-cycle strobe for a new `result_o` |
| frame_err_o | output | 1 | Leading-zero check failed for this sample |

## Verification
Each result has a fixed due time, counted from the edge that takes `start_i`. In that cycle `cs_n_o` falls. The k-th `sclk_o` fall comes H + 2H(k-1) cycles later, and the chip select rises 33H cycles later on a read, with `valid_o` in that same cycle. `ready_o` returns Q cycles after the rise. The bench samples every output on the falling system-clock edge and counts cycles between observed transitions. This gives the setup time, each clock phase, the number of falls per frame and the quiet time. A converter model in the bench launches each bit on the chip-select and clock falls, so the word read back also shows that every sample landed in the right phase for all capture delays up to H-1.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // command codes seen on cmd_i
    typedef enum logic [1:0] {
        CMD_READ  = 2'b00,
        CMD_SLEEP = 2'b01,
        CMD_WAKE  = 2'b10,
        CMD_NONE  = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_QUIET
    } seq_st_e;

    localparam int FRAME_CLKS  = 16;  // clocks in a read or wake frame
    localparam int SLEEP_CLKS  = 3;   // stub frame length, between 2 and 9 falls
    localparam int WAKE_FRAMES = 3;   // dummy frames issued by a wake
    localparam int LEAD_ZEROS  = 2;   // zero bits ahead of the data

    function automatic int unsigned clocks_for(input cmd_e kind);
        return (kind == CMD_SLEEP) ? SLEEP_CLKS : FRAME_CLKS;
    endfunction

endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  cmd_e               cmd_i,
    input  logic [DIV_W-1:0]   half_div_i,
    input  logic [QUIET_W-1:0] quiet_i,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               ready_o,
    output logic               frame_start_o,
    output logic               fall_o,
    output logic               frame_end_o,
    output cmd_e               kind_o,
    output logic               last_o
);
    localparam int PH_W   = (DIV_W > QUIET_W) ? DIV_W : QUIET_W;
    localparam int EDGE_W = $clog2(FRAME_CLKS + 1);
    localparam int FR_W   = $clog2(WAKE_FRAMES + 1);

    seq_st_e           state;
    logic [PH_W-1:0]   ph_cnt, half_q, quiet_q, half_eff, quiet_eff, limit;
    logic [EDGE_W-1:0] edges, frame_len;
    logic [FR_W-1:0]   frames_left;
    cmd_e              kind_q;
    logic              cs_n_q, sclk_q;
    logic              accept, ph_done, more, new_frame, fall_now, end_now;

    always_comb begin
        half_eff  = (half_div_i == '0) ? PH_W'(1) : PH_W'(half_div_i);
        quiet_eff = (quiet_i == '0) ? PH_W'(1) : PH_W'(quiet_i);
        limit     = (state == ST_QUIET) ? quiet_q : half_q;
        ph_done   = (ph_cnt == limit - PH_W'(1));
        frame_len = EDGE_W'(clocks_for(kind_q));
        accept    = (state == ST_IDLE) && start_i && (cmd_i != CMD_NONE);
        more      = (frames_left > FR_W'(1));
        new_frame = accept || ((state == ST_QUIET) && ph_done && more);
        fall_now  = ph_done && ((state == ST_SETUP) ||
                                ((state == ST_HIGH) && (edges != frame_len)));
        end_now   = ph_done && (state == ST_HIGH) && (edges == frame_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ph_cnt      <= '0;
            half_q      <= PH_W'(1);
            quiet_q     <= PH_W'(1);
            edges       <= '0;
            frames_left <= '0;
            kind_q      <= CMD_READ;
            cs_n_q      <= 1'b1;
            sclk_q      <= 1'b1;
        end else begin
            if (accept) begin
                kind_q      <= cmd_i;
                frames_left <= (cmd_i == CMD_WAKE) ? FR_W'(WAKE_FRAMES) : FR_W'(1);
            end else if (new_frame) begin
                frames_left <= frames_left - FR_W'(1);
            end

            if (new_frame) begin
                state   <= ST_SETUP;
                cs_n_q  <= 1'b0;
                ph_cnt  <= '0;
                edges   <= '0;
                half_q  <= half_eff;
                quiet_q <= quiet_eff;
            end else if (fall_now) begin
                state  <= ST_LOW;
                sclk_q <= 1'b0;
                ph_cnt <= '0;
                edges  <= edges + EDGE_W'(1);
            end else if ((state == ST_LOW) && ph_done) begin
                state  <= ST_HIGH;
                sclk_q <= 1'b1;
                ph_cnt <= '0;
            end else if (end_now) begin
                state  <= ST_QUIET;
                cs_n_q <= 1'b1;
                ph_cnt <= '0;
            end else if ((state == ST_QUIET) && ph_done) begin
                state  <= ST_IDLE;
                ph_cnt <= '0;
            end else if (state != ST_IDLE) begin
                ph_cnt <= ph_cnt + PH_W'(1);
            end
        end
    end

    assign cs_n_o        = cs_n_q;
    assign sclk_o        = sclk_q;
    assign ready_o       = (state == ST_IDLE);
    assign frame_start_o = new_frame;
    assign fall_o        = fall_now;
    assign frame_end_o   = end_now;
    assign kind_o        = kind_q;
    assign last_o        = (frames_left == FR_W'(1));

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int W     = 12,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic             fall_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             sdo_i,
    output logic [W-1:0]     word_o
);
    localparam int IDX_W = $clog2(W + 1);

    logic [DLY_W-1:0] dly_q, cnt;
    logic             pend, take;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     word_q;

    // a sample falls due once the delay from its launch event has run out
    assign take = pend && (cnt == '0) && (idx < IDX_W'(W));

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= '0;
            cnt    <= '0;
            pend   <= 1'b0;
            idx    <= '0;
            word_q <= '0;
        end else begin
            if (frame_start_i) begin
                dly_q <= dly_i;
            end
            if (frame_start_i || fall_i) begin
                cnt  <= frame_start_i ? dly_i : dly_q;
                pend <= 1'b1;
            end else if (pend) begin
                if (cnt == '0) begin
                    pend <= 1'b0;
                end else begin
                    cnt <= cnt - DLY_W'(1);
                end
            end
            if (frame_start_i) begin
                idx <= '0;
            end else if (take) begin
                idx <= idx + IDX_W'(1);
            end
            if (take) begin
                word_q <= {word_q[W-2:0], sdo_i};
            end
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int DIV_W   = 8,
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [1:0]         cmd_i,
    input  logic [DIV_W-1:0]   half_div_i,
    input  logic [QUIET_W-1:0] quiet_i,
    input  logic [DIV_W-1:0]   cap_dly_i,
    input  logic               sdo_i,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               ready_o,
    output logic [DATA_W-1:0]  result_o,
    output logic               valid_o,
    output logic               frame_err_o
);
    localparam int WORD_W = DATA_W + LEAD_ZEROS;

    if (WORD_W > FRAME_CLKS) begin : g_width_bad
        $error("DATA_W does not fit in one frame");
    end

    cmd_e              cmd_v, kind;
    logic              frame_start, fall, frame_end, last;
    logic [DIV_W-1:0]  half_eff, dly_eff;
    logic [WORD_W-1:0] word;
    logic              asleep_q, valid_q, err_q;
    logic [DATA_W-1:0] result_q;

    assign cmd_v = cmd_e'(cmd_i);

    // the capture offset must land inside the current half period
    always_comb begin
        half_eff = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
        dly_eff  = (cap_dly_i >= half_eff) ? half_eff - DIV_W'(1) : cap_dly_i;
    end

    adc_rd_seq #(
        .DIV_W   (DIV_W),
        .QUIET_W (QUIET_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .cmd_i         (cmd_v),
        .half_div_i    (half_div_i),
        .quiet_i       (quiet_i),
        .cs_n_o        (cs_n_o),
        .sclk_o        (sclk_o),
        .ready_o       (ready_o),
        .frame_start_o (frame_start),
        .fall_o        (fall),
        .frame_end_o   (frame_end),
        .kind_o        (kind),
        .last_o        (last)
    );

    adc_rd_capture #(
        .W     (WORD_W),
        .DLY_W (DIV_W)
    ) u_cap (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start),
        .fall_i        (fall),
        .dly_i         (dly_eff),
        .sdo_i         (sdo_i),
        .word_o        (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            asleep_q <= 1'b0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            result_q <= '0;
        end else begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (frame_end) begin
                unique case (kind)
                    CMD_SLEEP: asleep_q <= 1'b1;
                    CMD_WAKE: begin
                        if (last) begin
                            asleep_q <= 1'b0;
                        end
                    end
                    default: begin
                        if (!asleep_q) begin
                            valid_q  <= 1'b1;
                            result_q <= word[DATA_W-1:0];
                            err_q    <= |word[WORD_W-1:DATA_W];
                        end
                    end
                endcase
            end
        end
    end

    assign valid_o     = valid_q;
    assign frame_err_o = err_q;
    assign result_o    = result_q;

endmodule

// File: rtl/adc_rd_check.sv
module adc_rd_check (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic ready,
    input logic valid,
    input logic err
);
    // R1
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R1
    cs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> sclk);

    // R3
    valid_edge_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> $rose(cs_n));

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R4
    err_valid_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> valid);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (cs_n && sclk));

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> !ready);

endmodule

bind adc_frame_reader adc_rd_check u_chk (
    .clk   (clk),
    .rst   (rst),
    .cs_n  (cs_n_o),
    .sclk  (sclk_o),
    .ready (ready_o),
    .valid (valid_o),
    .err   (frame_err_o)
);

// File: tb/adc_frame_reader_tb.sv
module adc_frame_reader_tb;
    localparam int DW  = 10;
    localparam int DVW = 8;
    localparam int QW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic           start = 1'b0;
    logic [1:0]     cmd = 2'b00;
    logic [DVW-1:0] half_div = 8'd1;
    logic [QW-1:0]  quiet = 8'd1;
    logic [DVW-1:0] cap_dly = 8'd0;
    logic           sdo = 1'b0;
    logic           cs_n, sclk, ready, valid, ferr;
    logic [DW-1:0]  result;

    adc_frame_reader #(.DATA_W(DW), .DIV_W(DVW), .QUIET_W(QW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .cmd_i(cmd),
        .half_div_i(half_div), .quiet_i(quiet), .cap_dly_i(cap_dly),
        .sdo_i(sdo), .cs_n_o(cs_n), .sclk_o(sclk), .ready_o(ready),
        .result_o(result), .valid_o(valid), .frame_err_o(ferr)
    );

    // converter model: a bit is launched on the select fall and on each clock fall
    logic [15:0] word = '0;
    int bitpos = 0;
    always @(negedge cs_n) begin
        bitpos = 0;
        sdo = word[15];
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            bitpos++;
            sdo = (bitpos <= 15) ? word[15-bitpos] : 1'b0;
        end
    end

    int total = 0, bad = 0;
    bit finished = 0;
    int falls, setup_len, since_cs, ph, ph_min, ph_max, frames, valids, starts;
    int hi_cnt, gap_min, gap_max, fall_min, fall_max, not_ready;
    logic [DW-1:0] got;
    logic got_err;
    logic pcs = 1'b1, psclk = 1'b1;

    task automatic clear_stats();
        falls = 0; setup_len = -1; since_cs = 0; ph = 0; ph_min = 1000; ph_max = 0;
        frames = 0; valids = 0; starts = 0; hi_cnt = 0; gap_min = 1000; gap_max = 0;
        fall_min = 1000; fall_max = 0; not_ready = 0; got = '0; got_err = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pcs = 1'b1;
            psclk = 1'b1;
        end else begin
            if (valid) begin
                valids++;
                got = result;
                got_err = ferr;
            end
            if (!ready) not_ready++;
            if (pcs && !cs_n) begin
                starts++;
                if (starts > 1) begin
                    if (hi_cnt < gap_min) gap_min = hi_cnt;
                    if (hi_cnt > gap_max) gap_max = hi_cnt;
                end
                falls = 0; since_cs = 0; ph = 0;
            end
            if (!cs_n) begin
                if (psclk != sclk) begin
                    if (!sclk && falls == 0) setup_len = since_cs;
                    else begin
                        if (ph < ph_min) ph_min = ph;
                        if (ph > ph_max) ph_max = ph;
                    end
                    if (!sclk) falls++;
                    ph = 0;
                end
                since_cs++;
                ph++;
            end
            if (!pcs && cs_n) begin
                frames++;
                if (ph < ph_min) ph_min = ph;
                if (ph > ph_max) ph_max = ph;
                if (falls < fall_min) fall_min = falls;
                if (falls > fall_max) fall_max = falls;
                hi_cnt = 0;
            end
            if (cs_n && !ready) hi_cnt++;
            pcs = cs_n;
            psclk = sclk;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] c, input int h, input int q, input int d,
                       input logic [1:0] lead, input logic [DW-1:0] data, input bit poke);
        half_div = DVW'(h);
        quiet    = QW'(q);
        cap_dly  = DVW'(d);
        word     = {lead, data, {(14-DW){1'b0}}};
        @(negedge clk);
        clear_stats();
        cmd   = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            half_div = DVW'(h + 3);
            quiet    = QW'(q + 5);
            cap_dly  = '0;
        end
        for (int i = 0; i < 20000 && !ready; i++) @(negedge clk);
    endtask

    task automatic check_read(input string tag, input int h, input int q,
                              input logic [DW-1:0] data, input int err);
        int he = (h == 0) ? 1 : h;
        int qe = (q == 0) ? 1 : q;
        chk({tag, " R3 result"}, int'(got), int'(data));
        chk({tag, " R3 valid count"}, valids, 1);
        chk({tag, " R4 error flag"}, int'(got_err), err);
        chk({tag, " R1 falls"}, fall_max, 16);
        chk({tag, " R1 setup"}, setup_len, he);
        chk({tag, " R2 phase min"}, ph_min, he);
        chk({tag, " R2 phase max"}, ph_max, he);
        chk({tag, " R8 quiet"}, hi_cnt, qe);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 cs_n idle", int'(cs_n), 1);
        chk("R11 sclk idle", int'(sclk), 1);
        chk("R11 ready", int'(ready), 1);
        chk("R11 valid", int'(valid), 0);

        // R1 R2 R3 R8: sweep of divider, capture delay, quiet time and data
        for (int h = 0; h <= 3; h++) begin
            for (int d = 0; d < ((h == 0) ? 1 : h); d++) begin
                for (int qs = 0; qs < 2; qs++) begin
                    for (int k = 0; k < 4; k++) begin
                        int q = qs * 3;
                        logic [DW-1:0] data;
                        if (k == 0) data = '0;
                        else if (k == 1) data = '1;
                        else data = DW'(h * 97 + d * 31 + q * 13 + k * 211);
                        run(2'b00, h, q, d, 2'b00, data, 1'b0);
                        check_read("sweep", h, q, data, 0);
                    end
                end
            end
        end

        // R4: a nonzero leading bit flags the sample
        run(2'b00, 2, 2, 1, 2'b10, 10'h155, 1'b0);
        check_read("lead10", 2, 2, 10'h155, 1);
        run(2'b00, 3, 1, 2, 2'b01, 10'h0F3, 1'b0);
        check_read("lead01", 3, 1, 10'h0F3, 1);

        // R9: inputs changed mid frame have no effect on that frame
        run(2'b00, 2, 4, 1, 2'b00, 10'h2C7, 1'b1);
        check_read("R9 poke", 2, 4, 10'h2C7, 0);

        // R5: sleep stub
        run(2'b01, 2, 3, 0, 2'b00, 10'h3FF, 1'b0);
        chk("R5 sleep falls", fall_max, 3);
        chk("R5 sleep frames", frames, 1);
        chk("R5 sleep valids", valids, 0);
        chk("R5 sleep quiet", hi_cnt, 3);

        // R7: read while asleep gives no sample
        run(2'b00, 2, 2, 0, 2'b00, 10'h123, 1'b0);
        chk("R7 asleep falls", fall_max, 16);
        chk("R7 asleep valids", valids, 0);

        // R6: wake issues three full dummy frames
        run(2'b10, 1, 4, 0, 2'b00, 10'h0AA, 1'b0);
        chk("R6 wake frames", frames, 3);
        chk("R6 wake falls min", fall_min, 16);
        chk("R6 wake falls max", fall_max, 16);
        chk("R6 wake valids", valids, 0);
        chk("R8 wake gap min", gap_min, 4);
        chk("R8 wake gap max", gap_max, 4);

        // R6: sample returned again after wake
        run(2'b00, 1, 1, 0, 2'b00, 10'h321, 1'b0);
        check_read("R6 after wake", 1, 1, 10'h321, 0);

        // R10: reserved command does nothing
        run(2'b11, 2, 2, 0, 2'b00, 10'h1, 1'b0);
        repeat (40) @(negedge clk);
        chk("R10 frames", starts, 0);
        chk("R10 ready drops", not_ready, 0);
        chk("R10 valids", valids, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule